// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a small synchronous static memory with a register-to-register read pipeline. It sits behind a processor bus and serves single accesses and four-beat bursts. Every control input is sampled on the rising clock edge. An access can be opened by either of two address strobes. The processor strobe always starts as a read, and a write it starts is completed on the following edge. The controller strobe can write in the same edge that accepts it. Three chip selects gate every strobe. A two-bit burst counter walks the low address bits when the advance input is held low, in either linear or interleaved order.

The common data bus is split into `din`, `dout` and a drive enable `dq_oe`. The drive enable is cleared whenever a write is in progress. After a deselect it stays set for one more cycle, and it stays clear on the first cycle after the part is selected again. The output enable gates `dq_oe` without a clock.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `dq_oe` is 0.
- R2: Read data for an address accepted at clock edge k appears on `dout`, with `dq_oe` high (when `oe_n` is low), after edge k+1.
- R3: A low `pstb_n` has no effect while `sel0_n` is high: no new address is loaded and the part is not deselected.
- R4: An access opened by `pstb_n` ignores the write inputs at its opening edge. The write inputs sampled at the next edge perform the write at the captured address.
- R5: `cstb_n` low with `pstb_n` high, the chip selected and a write requested writes `din` at `addr` at that same edge.
- R6: `gw_n` low writes all lanes. Otherwise `bwe_n` low writes each lane i whose `lane_n[i]` is low, where lane i is bits [8i+7:8i]. Lanes that are not written keep their contents.
- R7: `dq_oe` is low in any cycle where `gw_n` is low or `bwe_n` is low with a lane selected. It is also low in the cycle after an edge that performed a write.
- R8: After a strobe is accepted with the chip not selected (selected means `sel0_n`=0, `sel1`=1, `sel2_n`=0), `dq_oe` may stay high for one more cycle and is low after the next edge.
- R9: On the first cycle after going from deselected to selected, `dq_oe` is low.
- R10: `oe_n` high forces `dq_oe` low without waiting for a clock edge.
- R11: With `burst_lin`=1, each edge with `adv_n` low and no strobe moves the two low address bits to (start+count) mod 4.
- R12: With `burst_lin`=0, the two low address bits follow start XOR count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| sel0_n | input | 1 | Chip select, active low; also gates pstb_n |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| burst_lin | input | 1 | 1 = linear burst, 0 = interleaved |
| oe_n | input | 1 | Output enable, active low |
| din | input | LANES*LW | Write data |
| dout | output | LANES*LW | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench opens a processor-strobe write with `gw_n` already low and then writes only the upper lane on the next edge. If the opening edge wrongly wrote, the lower byte would come back as the stale strobe data. It steps through deselect and reselect one cycle at a time: a single-cycle deselect would drop drive one cycle early, and a missing reselect rule would drive stale data one cycle early. It pulses `pstb_n` with `sel0_n` high during a held read, which a wrong design would take as a new address or a deselect. It also runs the same start address in both burst orders, where a swapped sequencer returns the words in a different order.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW    = 4,
  parameter int LANES = 2,
  parameter int LW    = 8,
  parameter int BB    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  pstb_n,
  input  logic                  cstb_n,
  input  logic                  sel0_n,
  input  logic                  sel1,
  input  logic                  sel2_n,
  input  logic                  adv_n,
  input  logic                  gw_n,
  input  logic                  bwe_n,
  input  logic [LANES-1:0]      lane_n,
  input  logic                  burst_lin,
  input  logic                  oe_n,
  input  logic [LANES*LW-1:0]   din,
  output logic [LANES*LW-1:0]   dout,
  output logic                  dq_oe
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    base, areg, cur_a, adv_a, rd_a, wr_a;
  logic [BB-1:0]    cnt;
  logic [LANES-1:0] wmask;
  logic sel_st, rd1, drv_q;
  logic sel_ok, p_acc, c_acc, strobe, start, cont, desel_evt;
  logic wr_req, wr_do, rd_do;

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] b,
                                             input logic [BB-1:0] c,
                                             input logic lin);
    logic [BB-1:0] lo;
    lo = lin ? (b[BB-1:0] + c) : (b[BB-1:0] ^ c);
    return {b[AW-1:BB], lo};
  endfunction

  assign sel_ok    = !sel0_n && sel1 && !sel2_n;
  assign p_acc     = !pstb_n && !sel0_n;
  assign c_acc     = !cstb_n && !p_acc;
  assign strobe    = p_acc || c_acc;
  assign start     = strobe && sel_ok;
  assign desel_evt = strobe && !sel_ok;
  assign cont      = !strobe && sel_st;

  assign wmask  = !gw_n ? '1 : (!bwe_n ? ~lane_n : '0);
  assign wr_req = |wmask;
  assign wr_do  = (start && c_acc && wr_req) || (cont && wr_req);
  assign rd_do  = (start && !(c_acc && wr_req)) || (cont && !wr_req);

  assign cur_a = seq_addr(base, cnt, burst_lin);
  assign adv_a = seq_addr(base, cnt + 1'b1, burst_lin);
  assign rd_a  = start ? addr : (adv_n ? cur_a : adv_a);
  assign wr_a  = start ? addr : cur_a;

  always_ff @(posedge clk) begin
    if (wr_do)
      for (int i = 0; i < LANES; i++)
        if (wmask[i]) mem[wr_a][i*LW +: LW] <= din[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_st <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      areg   <= '0;
      rd1    <= 1'b0;
      drv_q  <= 1'b0;
      dout   <= '0;
    end else begin
      if (strobe) sel_st <= sel_ok;
      if (start) begin
        base <= addr;
        cnt  <= '0;
      end else if (cont && !adv_n) begin
        cnt <= cnt + 1'b1;
      end
      rd1 <= rd_do;
      if (rd_do) areg <= rd_a;
      drv_q <= rd1 && !wr_do;
      if (rd1) dout <= mem[areg];
    end
  end

  assign dq_oe = drv_q && !oe_n && !wr_req;

  a_r7_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_do) |-> !dq_oe);
  a_r8_double_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $past(desel_evt, 2) |-> !drv_q);
  a_r9_reselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sel_st) |-> !dq_oe);
  a_r3_pstb_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0_n && cstb_n) |=> (sel_st == $past(sel_st)));
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic pstb_n = 1, cstb_n = 1, sel0_n = 0, sel1 = 1, sel2_n = 0;
  logic adv_n = 1, gw_n = 1, bwe_n = 1, burst_lin = 1, oe_n = 0;
  logic [1:0] lane_n = 2'b11;
  logic [15:0] din = '0, dout;
  logic dq_oe;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n),
    .cstb_n(cstb_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n), .burst_lin(burst_lin),
    .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe));

  typedef struct packed {
    logic p, c; logic [2:0] cs; logic adv, gw, bwe; logic [1:0] ln;
    logic lin, oe; logic [3:0] a; logic [15:0] d; logic eoe; logic [15:0] ed;
    logic [7:0] rq;
  } vec_t;

  localparam logic [2:0] SEL = 3'b010, DSA = 3'b110, DSB = 3'b000;
  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,SEL,1'b1,1'b0,1'b1,2'b11,1'b1,1'b1,4'h0,16'h1111,1'b0,16'h0000,8'd5},  // R5
    '{1'b1,1'b0,SEL,1'b1,1'b0,1'b1,2'b11,1'b1,1'b1,4'h1,16'h2222,1'b0,16'h0000,8'd5},
    '{1'b1,1'b0,SEL,1'b1,1'b0,1'b1,2'b11,1'b1,1'b1,4'h2,16'h3333,1'b0,16'h0000,8'd5},
    '{1'b1,1'b0,SEL,1'b1,1'b0,1'b1,2'b11,1'b1,1'b1,4'h3,16'h4444,1'b0,16'h0000,8'd5},
    '{1'b1,1'b0,SEL,1'b1,1'b1,1'b0,2'b10,1'b1,1'b1,4'h1,16'hABCD,1'b0,16'h0000,8'd6},  // R6 low lane
    '{1'b1,1'b0,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h1,16'h0000,1'b0,16'h0000,8'd2},  // R2
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h22CD,8'd2},
    '{1'b0,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h22CD,8'd2},
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h1111,8'd11}, // R11
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h22CD,8'd11},
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd11},
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h4444,8'd11},
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h1111,8'd11}, // wrap
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b1,4'h0,16'h0000,1'b0,16'h0000,8'd10}, // R10
    '{1'b1,1'b0,DSB,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h1111,8'd8},  // R8
    '{1'b1,1'b1,DSA,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b0,16'h0000,8'd8},
    '{1'b0,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h2,16'h0000,1'b0,16'h0000,8'd9},  // R9
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd9},
    '{1'b0,1'b1,DSA,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd3},  // R3
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd3},
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd3},
    '{1'b0,1'b1,SEL,1'b1,1'b0,1'b1,2'b11,1'b1,1'b1,4'h3,16'hDEAD,1'b0,16'h0000,8'd4},  // R4
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b0,2'b01,1'b1,1'b1,4'h0,16'h5599,1'b0,16'h0000,8'd4},
    '{1'b1,1'b0,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h3,16'h0000,1'b0,16'h0000,8'd7},
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,4'h0,16'h0000,1'b1,16'h5544,8'd4},
    '{1'b1,1'b0,SEL,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,4'h1,16'h0000,1'b1,16'h5544,8'd12}, // R12
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b1,16'h22CD,8'd12},
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b1,16'h1111,8'd12},
    '{1'b1,1'b1,SEL,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b1,16'h5544,8'd12},
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd12},
    '{1'b0,1'b1,SEL,1'b1,1'b0,1'b1,2'b11,1'b0,1'b0,4'h2,16'h0000,1'b0,16'h0000,8'd7},  // R7
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b1,16'h3333,8'd4},
    '{1'b1,1'b0,SEL,1'b1,1'b0,1'b1,2'b11,1'b0,1'b1,4'h0,16'h7777,1'b0,16'h0000,8'd5},
    '{1'b1,1'b0,SEL,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b0,16'h0000,8'd7},
    '{1'b1,1'b1,SEL,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,4'h0,16'h0000,1'b1,16'h7777,8'd5}
  };

  task automatic chk(input int rq, input int idx, input logic eoe, input logic [15:0] ed);
    checks++;
    if (dq_oe !== eoe || (eoe && dout !== ed)) begin
      failures++;
      $display("FAIL R%0d step %0d: dq_oe=%b dout=%h expected dq_oe=%b dout=%h",
               rq, idx, dq_oe, dout, eoe, ed);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet while in reset
    checks++;
    if (dout !== 16'h0 || dq_oe !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: dq_oe=%b dout=%h expected 0 0000", dq_oe, dout);
    end
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      pstb_n = VEC[i].p;  cstb_n = VEC[i].c;
      {sel0_n, sel1, sel2_n} = VEC[i].cs;
      adv_n = VEC[i].adv; gw_n = VEC[i].gw; bwe_n = VEC[i].bwe;
      lane_n = VEC[i].ln; burst_lin = VEC[i].lin; oe_n = VEC[i].oe;
      addr = VEC[i].a; din = VEC[i].d;
      @(posedge clk);
      #1;
      chk(int'(VEC[i].rq), i, VEC[i].eoe, VEC[i].ed);
    end
    // R10: raising oe_n drops drive at once, lowering restores it
    oe_n = 1'b1; #0.5;
    chk(10, 100, 1'b0, 16'h0);
    oe_n = 1'b0; #0.5;
    chk(10, 101, 1'b1, 16'h7777);
    // R7: write request alone forces tristate within the cycle
    bwe_n = 1'b0; lane_n = 2'b01; #0.5;
    chk(7, 102, 1'b0, 16'h0);
    bwe_n = 1'b1; lane_n = 2'b11; #0.5;
    chk(7, 103, 1'b1, 16'h7777);
    // R1: reset in mid-run clears outputs
    rst_n = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (dout !== 16'h0 || dq_oe !== 1'b0) begin
      failures++;
      $display("FAIL R1 mid reset: dq_oe=%b dout=%h expected 0 0000", dq_oe, dout);
    end
    summary();
  end
endmodule